// File: doc/BRIEF.md
# Time-Multiplexed Differential Equation Solver

This block integrates a second-order differential equation by explicit stepping. It holds three state variables, a position x, a velocity-like term u and an output y, together with a bound a and a step dx. Each iteration replaces all three from their previous values: x becomes x + dx, y becomes y + u*dx, and u becomes u - 5*x*u*dx - 3*y*dx. The loop runs while x is below a. Once that test fails, the current y is returned.

The block has one small arithmetic core, made of two multipliers, an adder, a subtractor and a signed less-than comparator. It reuses that core over a fixed schedule of four slots per iteration. A slot tag held in the controller decides which stored operands feed each unit and where each result is written. A caller applies the five operands together with a one-cycle start pulse. It then waits for the one-cycle done pulse, and the result stays on its port until a later run completes.

Top module: `ode_stepper`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: Each iteration updates x to x + dx, y to y + u*dx and u to u - 5*x*u*dx - 3*y*dx, with every right-hand side taken from the values held before that iteration. The value reported on result is the y held when the loop stops.
- R3: An iteration runs only while x < a. When x0 >= a at start, the result is y0 unchanged.
- R4: A run with N iterations raises done exactly 2 + 4*N clock edges after the edge that samples start. The slots follow the fixed order 1, 2, 3, 4, 1, and slot 2 either ends the run or moves on to slot 3.
- R5: All values are W-bit (default 16) two's-complement numbers. Every product, sum and difference keeps only its low W bits, so overflow wraps around.
- R6: A start pulse that arrives while a run is in progress is ignored. It neither changes that run's result or timing nor starts a second run.
- R7: done is high for exactly one cycle per run.
- R8: result changes only in the cycle in which done is high. Between runs, and during a run until its own done, it holds the previous value.
- R9: The x < a test compares signed values. With a = -1 and x0 = 3, no iteration runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run; sampled only when idle |
| a | input | W | Signed bound on x |
| dx | input | W | Signed step |
| x0 | input | W | Initial x |
| u0 | input | W | Initial u |
| y0 | input | W | Initial y |
| done | output | 1 | One-cycle pulse marking a finished run |
| result | output | W | Final y of the last finished run, held |

## Verification
The bound checker checks on every cycle that the slot tag steps 1→2→3→4→1 and that slot 2 leaves only to slot 3 or to idle. It also checks that a start seen while idle always enters slot 1, that done follows slot 2 and lasts a single cycle, and that result never moves outside a done cycle. The arithmetic cannot be seen from those properties. Only the bench's directed runs can show it, by comparing results against a wrapped 16-bit model for ordinary, overflowing, negative and zero-iteration inputs. The same runs check the exact 2 + 4*N latency, the signed bound test, and that a start pulse issued during a run is ignored.

// File: rtl/ode_pkg.sv
package ode_pkg;

    // Schedule position of the shared arithmetic core.
    typedef enum logic [2:0] {
        SLOT_IDLE = 3'd0,
        SLOT_1    = 3'd1,
        SLOT_2    = 3'd2,
        SLOT_3    = 3'd3,
        SLOT_4    = 3'd4
    } slot_t;

    localparam int unsigned NUM_MUL   = 2;
    localparam int unsigned COEF_U    = 5;
    localparam int unsigned COEF_Y    = 3;

endpackage

// File: rtl/ode_units.sv
module ode_units #(
    parameter int unsigned W    = 16,
    parameter int unsigned NMUL = 2
) (
    input  logic [NMUL-1:0][W-1:0] mul_a,
    input  logic [NMUL-1:0][W-1:0] mul_b,
    output logic [NMUL-1:0][W-1:0] mul_y,
    input  logic [W-1:0]           add_a,
    input  logic [W-1:0]           add_b,
    output logic [W-1:0]           add_y,
    input  logic [W-1:0]           sub_a,
    input  logic [W-1:0]           sub_b,
    output logic [W-1:0]           sub_y,
    input  logic [W-1:0]           cmp_a,
    input  logic [W-1:0]           cmp_b,
    output logic                   cmp_lt
);

    // Truncating multipliers: low W bits of the product (wraparound).
    for (genvar g = 0; g < NMUL; g++) begin : g_mul
        assign mul_y[g] = mul_a[g] * mul_b[g];
    end

    assign add_y  = add_a + add_b;
    assign sub_y  = sub_a - sub_b;
    assign cmp_lt = $signed(cmp_a) < $signed(cmp_b);

endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl
    import ode_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [W-1:0]              a,
    input  logic [W-1:0]              dx,
    input  logic [W-1:0]              x0,
    input  logic [W-1:0]              u0,
    input  logic [W-1:0]              y0,
    output logic [NUM_MUL-1:0][W-1:0] mul_a,
    output logic [NUM_MUL-1:0][W-1:0] mul_b,
    input  logic [NUM_MUL-1:0][W-1:0] mul_y,
    output logic [W-1:0]              add_a,
    output logic [W-1:0]              add_b,
    input  logic [W-1:0]              add_y,
    output logic [W-1:0]              sub_a,
    output logic [W-1:0]              sub_b,
    input  logic [W-1:0]              sub_y,
    output logic [W-1:0]              cmp_a,
    output logic [W-1:0]              cmp_b,
    input  logic                      cmp_lt,
    output slot_t                     slot,
    output logic                      done,
    output logic [W-1:0]              result
);

    localparam logic [W-1:0] K_U = W'(COEF_U);
    localparam logic [W-1:0] K_Y = W'(COEF_Y);

    // Continuation: slot tag plus the live fields it carries.
    typedef struct packed {
        slot_t        tag;
        logic [W-1:0] bound;
        logic [W-1:0] step;
        logic [W-1:0] xv;
        logic [W-1:0] uv;
        logic [W-1:0] yv;
        logic [W-1:0] pa;
        logic [W-1:0] pb;
        logic         below;
        logic         fin;
        logic [W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    // Operand routing, a function of the held continuation only.
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        add_a = '0;
        add_b = '0;
        sub_a = '0;
        sub_b = '0;
        cmp_a = '0;
        cmp_b = '0;
        case (st_q.tag)
            SLOT_1: begin
                mul_a[0] = st_q.uv;    mul_b[0] = st_q.step;
                mul_a[1] = K_U;        mul_b[1] = st_q.xv;
                add_a    = st_q.xv;    add_b    = st_q.step;
                cmp_a    = st_q.xv;    cmp_b    = st_q.bound;
            end
            SLOT_2: begin
                mul_a[0] = st_q.pa;    mul_b[0] = st_q.pb;
                mul_a[1] = K_Y;        mul_b[1] = st_q.yv;
            end
            SLOT_3: begin
                mul_a[0] = st_q.uv;    mul_b[0] = st_q.step;
                mul_a[1] = st_q.step;  mul_b[1] = st_q.pb;
                sub_a    = st_q.uv;    sub_b    = st_q.pa;
            end
            SLOT_4: begin
                add_a    = st_q.yv;    add_b    = st_q.pa;
                sub_a    = st_q.uv;    sub_b    = st_q.pb;
            end
            default: ;
        endcase
    end

    // Next continuation from the unit results.
    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        case (st_q.tag)
            SLOT_IDLE: begin
                if (start) begin
                    st_d.tag   = SLOT_1;
                    st_d.bound = a;
                    st_d.step  = dx;
                    st_d.xv    = x0;
                    st_d.uv    = u0;
                    st_d.yv    = y0;
                end
            end
            SLOT_1: begin
                st_d.pa    = mul_y[0];      // u*dx
                st_d.pb    = mul_y[1];      // 5*x
                st_d.xv    = add_y;         // x + dx
                st_d.below = cmp_lt;        // x < a
                st_d.tag   = SLOT_2;
            end
            SLOT_2: begin
                if (!st_q.below) begin
                    st_d.fin = 1'b1;
                    st_d.res = st_q.yv;
                    st_d.tag = SLOT_IDLE;
                end else begin
                    st_d.pa  = mul_y[0];    // 5*x*u*dx
                    st_d.pb  = mul_y[1];    // 3*y
                    st_d.tag = SLOT_3;
                end
            end
            SLOT_3: begin
                st_d.pa  = mul_y[0];        // u*dx
                st_d.pb  = mul_y[1];        // 3*y*dx
                st_d.uv  = sub_y;           // u - 5*x*u*dx
                st_d.tag = SLOT_4;
            end
            SLOT_4: begin
                st_d.yv  = add_y;           // y + u*dx
                st_d.uv  = sub_y;           // minus 3*y*dx
                st_d.tag = SLOT_1;
            end
            default: st_d.tag = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tag <= SLOT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot   = st_q.tag;
    assign done   = st_q.fin;
    assign result = st_q.res;

endmodule

// File: rtl/ode_stepper.sv
module ode_stepper
    import ode_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] dx,
    input  logic [W-1:0] x0,
    input  logic [W-1:0] u0,
    input  logic [W-1:0] y0,
    output logic         done,
    output logic [W-1:0] result
);

    logic [NUM_MUL-1:0][W-1:0] mul_a, mul_b, mul_y;
    logic [W-1:0]              add_a, add_b, add_y;
    logic [W-1:0]              sub_a, sub_b, sub_y;
    logic [W-1:0]              cmp_a, cmp_b;
    logic                      cmp_lt;
    slot_t                     slot_w;

    ode_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .a      (a),
        .dx     (dx),
        .x0     (x0),
        .u0     (u0),
        .y0     (y0),
        .mul_a  (mul_a),
        .mul_b  (mul_b),
        .mul_y  (mul_y),
        .add_a  (add_a),
        .add_b  (add_b),
        .add_y  (add_y),
        .sub_a  (sub_a),
        .sub_b  (sub_b),
        .sub_y  (sub_y),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .cmp_lt (cmp_lt),
        .slot   (slot_w),
        .done   (done),
        .result (result)
    );

    ode_units #(.W(W), .NMUL(NUM_MUL)) u_units (
        .mul_a  (mul_a),
        .mul_b  (mul_b),
        .mul_y  (mul_y),
        .add_a  (add_a),
        .add_b  (add_b),
        .add_y  (add_y),
        .sub_a  (sub_a),
        .sub_b  (sub_b),
        .sub_y  (sub_y),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .cmp_lt (cmp_lt)
    );

endmodule

// File: rtl/ode_stepper_chk.sv
module ode_stepper_chk
    import ode_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] result,
    input slot_t        slot
);

    // R4: fixed slot order
    a_r4_slot1_to_2: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_1 |=> slot == SLOT_2);
    a_r4_slot3_to_4: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_3 |=> slot == SLOT_4);
    a_r4_slot4_to_1: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_4 |=> slot == SLOT_1);
    a_r4_slot2_exit: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SLOT_2 |=> (slot == SLOT_3 || slot == SLOT_IDLE));

    // R6: start is taken only from idle, and always taken there
    a_r6_start_accepted_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_IDLE && start) |=> slot == SLOT_1);
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_IDLE && !start) |=> slot == SLOT_IDLE);

    // R3: a run finishes only out of slot 2
    a_r3_done_after_slot2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slot) == SLOT_2 && slot == SLOT_IDLE));

    // R7: single-cycle done
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: result moves only with done
    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind ode_stepper ode_stepper_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .slot   (slot_w)
);

// File: tb/ode_stepper_test.sv
`timescale 1ns/1ps
module ode_stepper_test;

    localparam int W = 16;
    localparam int WAIT_LIMIT = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a = '0, dx = '0, x0 = '0, u0 = '0, y0 = '0;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    ode_stepper #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a(a), .dx(dx), .x0(x0), .u0(u0), .y0(y0),
        .done(done), .result(result)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model built from R2/R3/R5/R9: wrapped W-bit arithmetic.
    task automatic model(input logic [W-1:0] ai, dxi, xi, ui, yi,
                         output logic [W-1:0] yr, output int n);
        logic [W-1:0] x = xi, u = ui, y = yi;
        logic [W-1:0] t1, t2, t3;
        n = 0;
        while ($signed(x) < $signed(ai) && n < 1000) begin
            t1 = u * dxi;
            t2 = t1 * (x * W'(5));
            t3 = dxi * (y * W'(3));
            x = x + dxi;
            u = u - t2 - t3;
            y = y + t1;
            n++;
        end
        yr = y;
    endtask

    task automatic drive_ops(input logic [W-1:0] ai, dxi, xi, ui, yi);
        a = ai; dx = dxi; x0 = xi; u0 = ui; y0 = yi;
    endtask

    // Waits for done; edges counts clock edges since the start-sampling edge.
    task automatic wait_done(inout int edges);
        int guard = 0;
        while (!done && guard < WAIT_LIMIT) begin
            @(negedge clk);
            edges++;
            guard++;
        end
        if (!done) chk("R4", "done never arrived", 0, 1);
    endtask

    task automatic run_case(input string tag, input logic [W-1:0] ai, dxi, xi, ui, yi);
        logic [W-1:0] exp_y;
        logic [W-1:0] prev;
        int n;
        int edges;
        model(ai, dxi, xi, ui, yi, exp_y, n);
        prev = result;
        drive_ops(ai, dxi, xi, ui, yi);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        if (!done) begin
            chk("R8", {tag, " result held at run begin"}, int'(result), int'(prev));
        end
        wait_done(edges);
        chk("R2", {tag, " result"}, int'($signed(result)), int'($signed(exp_y)));
        chk("R4", {tag, " latency"}, edges, 2 + 4 * n);
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, int'(done), 0);
        repeat (3) @(negedge clk);
        chk("R8", {tag, " result held after done"}, int'($signed(result)), int'($signed(exp_y)));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "result in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "result after reset", int'(result), 0);
    endtask

    task automatic t_no_iteration();
        // R3: x0 >= a returns y0 after 2 edges
        run_case("R3 equal bound", 16'd5, 16'd1, 16'd5, 16'd9, 16'd77);
        chk("R3", "y0 returned", int'(result), 77);
        // R9: signed compare, 3 < -1 is false
        run_case("R9 signed bound", 16'hFFFF, 16'd1, 16'd3, 16'd4, 16'd123);
        chk("R9", "no iteration with negative bound", int'(result), 123);
    endtask

    task automatic t_iterations();
        run_case("R2 one step", 16'd1, 16'd1, 16'd0, 16'd2, 16'd10);
        chk("R2", "one step y = y0 + u0*dx", int'(result), 12);
        run_case("R2 five steps", 16'd10, 16'd2, 16'd0, 16'd1, 16'd0);
        run_case("R9 negative range", 16'hFFFB, 16'd1, 16'hFFEC, 16'hFFFD, 16'd7);
    endtask

    task automatic t_wrap();
        run_case("R5 overflow", 16'd100, 16'd50, 16'd0, 16'd300, 16'd1000);
        run_case("R5 large products", 16'd3, 16'd1, 16'd0, 16'h7FFF, 16'h4000);
    endtask

    task automatic t_busy_start();
        logic [W-1:0] exp_y;
        int n;
        int edges;
        int extra;
        model(16'd6, 16'd1, 16'd0, 16'd3, 16'd2, exp_y, n);
        drive_ops(16'd6, 16'd1, 16'd0, 16'd3, 16'd2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 1;
        repeat (3) begin
            @(negedge clk);
            edges++;
        end
        drive_ops(16'd2, 16'd1, 16'd0, 16'd1, 16'd500);
        start = 1'b1;
        @(negedge clk);
        edges++;
        start = 1'b0;
        edges = edges - 1;
        wait_done(edges);
        chk("R6", "result unaffected by busy start", int'($signed(result)), int'($signed(exp_y)));
        chk("R6", "latency unaffected by busy start", edges, 2 + 4 * n);
        extra = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R6", "no second run from busy start", extra, 0);
        chk("R8", "result held while idle", int'($signed(result)), int'($signed(exp_y)));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_no_iteration();
        t_iterations();
        t_wrap();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule